// File: doc/BRIEF.md
# Tuning Tap Window Selector

After a sampling-phase tuning sweep, this block picks the clock phase tap to keep. The sweep records one pass/fail bit per tap over two whole clock periods, so the bitmap has 2×N bits, where N is the number of taps in a period. A one-cycle strobe on `start_i` hands the block that bitmap and the tap count. The block first folds the two halves together, so that a tap counts as passing only if both of its copies passed. It then scans the folded map for the longest unbroken run of passing positions. It reports the centre of that run, reduced modulo N, or it flags an error when no run is long enough.

The work is sequenced by a state machine. `ST_IDLE` waits for the strobe. `ST_FOLD` masks one bitmap position per clock. `ST_SCAN` tracks runs, one position per clock. `ST_FINAL` closes any run still open and computes the result. `ST_REPORT` shows the result for one cycle.

The transitions are as follows:
- `ST_IDLE -> ST_FOLD` on an accepted start when N is 1 or more.
- `ST_IDLE -> ST_FINAL` on an accepted start when N is 0.
- `ST_FOLD -> ST_SCAN` after the last position, 2N-1.
- `ST_SCAN -> ST_FINAL` after position 2N-1.
- `ST_FINAL -> ST_REPORT` always.
- `ST_REPORT -> ST_IDLE` always.

Top module: `tws_window_sel`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `error_o` are 0 and `tap_o` is 0.
- R2: A start seen in `ST_IDLE` latches the bitmap and the tap count, and `busy_o` stays 1 until the report cycle ends. A start while `busy_o` is 1 is ignored: it changes neither the result nor the number of done pulses.
- R3: Bitmap bit k is tap k of the first period for k < N, and tap k-N of the second period otherwise. A tap is treated as passing only if bits k and k+N are both 1.
- R4: The folded map, positions 0 to 2N-1, is searched for its longest run of consecutive passing positions. A run that reaches position 2N-1 counts. Bitmap bits at or above 2N have no effect.
- R5: When several longest runs have equal length, the one that starts at the lowest position is kept.
- R6: When the longest run is shorter than 3 positions, `error_o` is 1 during the done cycle and `tap_o` keeps its previous value.
- R7: Otherwise `tap_o` becomes ((start + end) / 2) mod N, with integer division, where start and end are the first and last positions of the chosen run. `error_o` is 0.
- R8: `done_o` is a single-cycle pulse that is 1 exactly 4N+1 clock edges after the edge that accepted the start.
- R9: A tap count above 16 is treated as 16. A tap count of 0 gives an error report 1 edge after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to evaluate the bitmap |
| tap_count_i | input | 5 | Taps per clock period, N |
| pass_map_i | input | 32 | Pass/fail bits for 2N taps, position k at bit k |
| busy_o | output | 1 | The block is evaluating or reporting |
| done_o | output | 1 | One-cycle result strobe |
| error_o | output | 1 | No passing window long enough, valid with `done_o` |
| tap_o | output | 4 | Selected tap, held between results |

## Verification
Each bitmap pattern isolates one rule of the block:
- A fully passing map exercises the run that stays open to the last position.
- A map whose halves disagree shows that folding masks a tap failing in only one period.
- Two equal windows show the earliest-run tie rule.
- A window that crosses the period boundary checks the reduction modulo N.
- Runs of exactly 2 and 3 taps sit on either side of the error threshold.
- Set bits above 2N, together with counts of 0, 1, 2 and above 16, exercise masking and clamping.
- A second start given mid-evaluation must leave both the result and the done count unchanged.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FOLD,
        ST_SCAN,
        ST_FINAL,
        ST_REPORT
    } tws_state_e;

endpackage

// File: rtl/tws_fold_step.sv
// Masks the partner of one bitmap position when that position failed.
module tws_fold_step #(
    parameter int MAP_W = 32,
    parameter int IDX_W = 6,
    parameter int NW    = 5
) (
    input  logic [MAP_W-1:0] map_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [NW-1:0]    n_i,
    output logic [MAP_W-1:0] map_o
);
    logic [IDX_W-1:0] n_ext;
    logic [IDX_W-1:0] partner;
    logic             cur_bit;

    assign n_ext   = IDX_W'(n_i);
    assign partner = (idx_i < n_ext) ? (idx_i + n_ext) : (idx_i - n_ext);
    assign cur_bit = map_i[idx_i[IDX_W-2:0]];

    for (genvar j = 0; j < MAP_W; j++) begin : g_bit
        assign map_o[j] = map_i[j] & ~(~cur_bit && (partner == IDX_W'(j)));
    end
endmodule

// File: rtl/tws_run_track.sv
// Tracks the current run and the best run; best_*_d give the values after this cycle.
module tws_run_track #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             bit_i,
    input  logic             close_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] best_start_d,
    output logic [IDX_W-1:0] best_len_d
);
    logic [IDX_W-1:0] run_q, run_d;
    logic [IDX_W-1:0] best_start_q, best_len_q;
    logic             run_ends, take;

    always_comb begin
        run_ends     = close_i | (step_i & ~bit_i);
        take         = run_ends && (run_q > best_len_q);
        best_len_d   = take ? run_q : best_len_q;
        best_start_d = take ? (idx_i - run_q) : best_start_q;
        if (step_i && bit_i)
            run_d = run_q + 1'b1;
        else if (run_ends)
            run_d = '0;
        else
            run_d = run_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q        <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
        end else if (clear_i) begin
            run_q        <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
        end else begin
            run_q        <= run_d;
            best_start_q <= best_start_d;
            best_len_q   <= best_len_d;
        end
    end
endmodule

// File: rtl/tws_tap_pick.sv
// Centre of the chosen run folded into 0..N-1, plus the length check.
module tws_tap_pick #(
    parameter int IDX_W   = 6,
    parameter int NW      = 5,
    parameter int TW      = 4,
    parameter int MIN_RUN = 3
) (
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] len_i,
    input  logic [NW-1:0]    n_i,
    output logic [TW-1:0]    tap_o,
    output logic             short_o
);
    logic [IDX_W:0]   sum;
    logic [IDX_W-1:0] centre;
    logic [IDX_W-1:0] n_ext;
    logic [IDX_W-1:0] wrapped;

    always_comb begin
        n_ext   = IDX_W'(n_i);
        short_o = (len_i < IDX_W'(MIN_RUN));
        sum     = {start_i, 1'b0} + {1'b0, len_i} - 1'b1;
        if (len_i == '0)
            sum = '0;
        centre  = sum[IDX_W:1];
        wrapped = (centre >= n_ext) ? (centre - n_ext) : centre;
        tap_o   = wrapped[TW-1:0];
    end
endmodule

// File: rtl/tws_window_sel.sv
module tws_window_sel
    import tws_pkg::*;
#(
    parameter int TAP_MAX = 16,
    parameter int MIN_RUN = 3,
    localparam int MAP_W  = 2 * TAP_MAX,
    localparam int IDX_W  = $clog2(MAP_W) + 1,
    localparam int NW     = $clog2(TAP_MAX + 1),
    localparam int TW     = $clog2(TAP_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NW-1:0]    tap_count_i,
    input  logic [MAP_W-1:0] pass_map_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o,
    output logic [TW-1:0]    tap_o
);
    tws_state_e       state_q, state_d;
    logic [MAP_W-1:0] map_q, folded, in_mask;
    logic [NW-1:0]    n_q, n_eff;
    logic [IDX_W-1:0] idx_q, span, last_idx;
    logic [TW-1:0]    tap_q, pick_tap;
    logic             err_q, pick_short;
    logic             accept, in_fold, in_scan, in_final;
    logic [IDX_W-1:0] best_start_d, best_len_d;

    assign n_eff    = (tap_count_i > NW'(TAP_MAX)) ? NW'(TAP_MAX) : tap_count_i;
    assign span     = IDX_W'(n_q) << 1;
    assign last_idx = span - 1'b1;
    assign accept   = (state_q == ST_IDLE) && start_i;
    assign in_fold  = (state_q == ST_FOLD);
    assign in_scan  = (state_q == ST_SCAN);
    assign in_final = (state_q == ST_FINAL);

    for (genvar j = 0; j < MAP_W; j++) begin : g_mask
        assign in_mask[j] = (IDX_W'(j) < (IDX_W'(n_eff) << 1));
    end

    tws_fold_step #(.MAP_W(MAP_W), .IDX_W(IDX_W), .NW(NW)) u_fold (
        .map_i (map_q),
        .idx_i (idx_q),
        .n_i   (n_q),
        .map_o (folded)
    );

    tws_run_track #(.IDX_W(IDX_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (accept),
        .step_i       (in_scan),
        .bit_i        (map_q[idx_q[IDX_W-2:0]]),
        .close_i      (in_final),
        .idx_i        (idx_q),
        .best_start_d (best_start_d),
        .best_len_d   (best_len_d)
    );

    tws_tap_pick #(.IDX_W(IDX_W), .NW(NW), .TW(TW), .MIN_RUN(MIN_RUN)) u_pick (
        .start_i (best_start_d),
        .len_i   (best_len_d),
        .n_i     (n_q),
        .tap_o   (pick_tap),
        .short_o (pick_short)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (n_eff == '0) ? ST_FINAL : ST_FOLD;
            ST_FOLD:   if (idx_q == last_idx) state_d = ST_SCAN;
            ST_SCAN:   if (idx_q == last_idx) state_d = ST_FINAL;
            ST_FINAL:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            map_q   <= '0;
            n_q     <= '0;
            idx_q   <= '0;
            tap_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        map_q <= pass_map_i & in_mask;
                        n_q   <= n_eff;
                        idx_q <= '0;
                    end
                end
                ST_FOLD: begin
                    map_q <= folded;
                    idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
                end
                ST_SCAN: idx_q <= idx_q + 1'b1;
                ST_FINAL: begin
                    err_q <= pick_short;
                    if (!pick_short)
                        tap_q <= pick_tap;
                end
                ST_REPORT: idx_q <= '0;
                default: idx_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        done_o  = (state_q == ST_REPORT);
        error_o = (state_q == ST_REPORT) && err_q;
        tap_o   = tap_q;
    end
endmodule

// File: rtl/tws_window_sel_chk.sv
module tws_window_sel_chk #(
    parameter int NW = 5,
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          error_o,
    input logic [TW-1:0] tap_o,
    input logic [NW-1:0] n_q
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R6
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap_o) |-> (done_o && !error_o));

    // R7
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> ({1'b0, tap_o} < (TW+1)'(n_q)));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2
    report_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

bind tws_window_sel tws_window_sel_chk #(.NW(NW), .TW(TW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .error_o (error_o),
    .tap_o   (tap_o),
    .n_q     (n_q)
);

// File: tb/tws_window_sel_tb_top.sv
`timescale 1ns/1ps
module tws_window_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  tap_count_i = '0;
    logic [31:0] pass_map_i = '0;
    logic        busy_o, done_o, error_o;
    logic [3:0]  tap_o;

    int checks = 0;
    int errors = 0;
    int last_tap = 0;

    always #5 clk = ~clk;

    tws_window_sel dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tap_count_i (tap_count_i),
        .pass_map_i  (pass_map_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .error_o     (error_o),
        .tap_o       (tap_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: fold by pairs, longest earliest run, centre mod n.
    task automatic model(input int n_in, input logic [31:0] m, output int tap, output bit err);
        int n;
        bit f[64];
        int run, best, bstart;
        n = (n_in > 16) ? 16 : n_in;
        run = 0; best = 0; bstart = 0;
        for (int k = 0; k < 2 * n; k++)
            f[k] = m[k % n] && m[(k % n) + n];
        for (int i = 0; i <= 2 * n; i++) begin
            if (i < 2 * n && f[i]) run++;
            else begin
                if (run > best) begin best = run; bstart = i - run; end
                run = 0;
            end
        end
        err = (best < 3);
        tap = err ? last_tap : ((2 * bstart + best - 1) / 2) % n;
    endtask

    task automatic run_case(input int n_in, input logic [31:0] m, input string req,
                            input bit poke);
        int n, lat, exp_tap;
        bit exp_err;
        n = (n_in > 16) ? 16 : n_in;
        lat = 4 * n + 1;
        model(n_in, m, exp_tap, exp_err);
        @(negedge clk);
        start_i = 1'b1; tap_count_i = 5'(n_in); pass_map_i = m;
        @(negedge clk);
        start_i = 1'b0; pass_map_i = ~m;
        for (int c = 1; c <= lat + 3; c++) begin
            if (poke && c == 2) begin
                start_i = 1'b1; tap_count_i = 5'd2; pass_map_i = 32'h0;
            end
            @(negedge clk);
            start_i = 1'b0;
            check(done_o == (c == lat), {req, " R8 done timing"}, done_o, (c == lat));
            check(busy_o == (c <= lat), "R2 busy", busy_o, (c <= lat));
            if (c == lat) begin
                check(error_o == exp_err, {req, " error"}, error_o, exp_err);
                check(tap_o == 4'(exp_tap), {req, " tap"}, tap_o, exp_tap);
            end else begin
                check(error_o == 1'b0, "R6 error only with done", error_o, 0);
            end
        end
        check(tap_o == 4'(exp_tap), {req, " tap held"}, tap_o, exp_tap);
        last_tap = exp_tap;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !error_o && tap_o == 0, "R1 reset", {busy_o, done_o, error_o, tap_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && tap_o == 0, "R1 after release", {busy_o, done_o, tap_o}, 0);

        run_case(8,  32'h0000_FFFF, "R4 full open run", 0);        // tap 7
        run_case(8,  32'h0000_3C3C, "R5 tie earliest", 0);         // tap 3
        run_case(8,  32'h0000_0FFF, "R3 fold mask", 0);            // tap 1
        run_case(8,  32'h0000_C3C3, "R7 wrap modulo", 0);          // tap 7
        run_case(8,  32'h0000_E1E1, "R7 boundary run", 0);         // tap 6
        run_case(8,  32'h0000_0303, "R6 run of two", 0);           // error
        run_case(8,  32'h0000_3838, "R6 run of three", 0);         // tap 4
        run_case(3,  32'hFFFF_FFFF, "R4 upper bits ignored", 0);   // tap 2
        run_case(20, 32'hFFFF_FFFF, "R9 clamp", 0);                // tap 15
        run_case(0,  32'hFFFF_FFFF, "R9 zero count", 0);           // error
        run_case(16, 32'h00F0_00F0, "R7 wide", 0);                 // tap 5
        run_case(1,  32'h0000_0003, "R6 single tap", 0);           // error
        run_case(2,  32'h0000_000F, "R7 two taps", 0);             // tap 1
        run_case(8,  32'h0000_3838, "R2 start ignored while busy", 1); // tap 4

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule